// File: doc/BRIEF.md
# Windowed Key-Sequence Watchdog

This block forces a system reset when software stops servicing it. Software reaches it through a small write port made of an address, a data byte and a strobe. One address holds a configuration register that can be written only once. It selects the timeout length, which clock the counter follows, and whether early service is penalised. A second address is the service address. Software services the watchdog there by writing a two-byte key sequence. Any byte that is not a key byte is treated as runaway code, and the block requests a reset at once.

The counter steps either on every bus clock or on a slow tick-enable input that pulses at about 1 kHz. A reset request can come from timeout expiry, from an illegal service byte, or from a premature service while the window check is active. Each request appears on `reset_req` as a one-cycle pulse in the cycle after its cause. The system reset controller that acts on this pulse is not part of the block.

Three state machines make up the block:
- **Configuration FSM.** It has the states CFG_OPEN and CFG_LOCKED. The transition "first write" moves it from CFG_OPEN to CFG_LOCKED. Only a reset returns it to CFG_OPEN.
- **Key FSM.** It has the states KEY_IDLE and KEY_ARMED. The transition "arm" (0x55) goes from KEY_IDLE to KEY_ARMED. The transition "re-arm" (0x55 again) keeps the FSM in KEY_ARMED. The transitions "fire" (0xAA) and "reject" (an illegal byte) return it from KEY_ARMED to KEY_IDLE. In KEY_IDLE, 0xAA and illegal bytes leave the state unchanged.
- **Counter phase.** It has the states PH_OFF, PH_CLOSED and PH_OPEN. PH_OFF holds while the timeout field is 0. In the other two states the count rises from PH_CLOSED into PH_OPEN when it enters the last quarter of the period. It wraps back to PH_CLOSED on expiry or restart.

Top module: `keyseq_watchdog`

## Requirements
- R1: After reset the watchdog is enabled, counts slow ticks, and uses the longest slow timeout (2^SLOW_EXP3 ticks, field value 3). With no service, a reset request follows after that many ticks.
- R2: When the count reaches the selected timeout, `reset_req` is high for exactly one clock in the next cycle, and the count restarts from zero.
- R3: A write of 0x55 followed later by a write of 0xAA to the service address (SVC_ADDR) restarts the count from zero. Only the 0xAA write restarts it.
- R4: A 0xAA written while no 0x55 is pending is ignored and does not restart the count. A 0x55 written while one is already pending keeps the sequence pending.
- R5: Writing any byte other than 0x55 or 0xAA to the service address raises `reset_req` in the next cycle.
- R6: Configuration bit 2 set selects counting on every bus clock. Bit 2 clear selects counting only on cycles where `tick_1k` is high.
- R7: Configuration bits [1:0] select the timeout. Values 1, 2 and 3 give 2^BUS_EXP1/2/3 bus cycles, or 2^SLOW_EXP1/2/3 ticks. Value 0 disables the counter, so no timeout request is made.
- R8: With configuration bit 3 set and the bus clock selected, a completing 0xAA is accepted only when the count is at least 3/4 of the timeout. An earlier completing write raises `reset_req` in the next cycle.
- R9: With the slow tick selected, bit 3 is ignored and a completing 0xAA is accepted at any count.
- R10: Only the first write to the configuration address (CFG_ADDR) after reset takes effect, and it clears the count. Later configuration writes change neither the settings nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1k | input | 1 | Slow count enable, one bus cycle wide per tick |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address (CFG_ADDR or SVC_ADDR) |
| wr_data | input | 8 | Write data byte |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
Some properties are checked on every cycle: an illegal service byte is always followed by a request, a pending 0x55 survives another 0x55, the count stays below the selected limit, the count does not move without a tick on the slow source, a locked configuration never changes, and a disabled counter never produces a request on its own. Other behaviour can only be shown by the bench's scenarios, which compare every cycle against a behavioural reference model. These are the exact timeout lengths for each field value and source, where the service window lies, that a lone 0xAA is ignored, that the counter is cleared on the first configuration write, and that later configuration writes have no effect on timing.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;

    typedef enum logic {
        CFG_OPEN   = 1'b0,
        CFG_LOCKED = 1'b1
    } cfg_state_e;

    typedef enum logic [1:0] {
        PH_OFF    = 2'd0,
        PH_CLOSED = 2'd1,
        PH_OPEN   = 2'd2
    } cnt_phase_e;

    // configuration byte layout, bits [3:0]
    typedef struct packed {
        logic       win;   // bit 3: early-service check
        logic       bus;   // bit 2: 1 = bus clock, 0 = slow tick
        logic [1:0] sel;   // bits [1:0]: timeout select, 0 = off
    } wdg_cfg_t;

    localparam logic [7:0] KEY_ARM_BYTE  = 8'h55;
    localparam logic [7:0] KEY_FIRE_BYTE = 8'hAA;

    localparam wdg_cfg_t CFG_DEFAULT = '{win: 1'b0, bus: 1'b0, sel: 2'd3};

endpackage

// File: rtl/wdg_cfg_reg.sv
module wdg_cfg_reg
    import wdg_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int CFG_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [3:0]        wr_field,
    output wdg_cfg_t          cfg,
    output logic              cfg_load,
    output logic              locked
);

    cfg_state_e state_q, state_d;
    wdg_cfg_t   cfg_q;
    logic       hit;

    assign hit = wr_en && (wr_addr == ADDR_W'(CFG_ADDR));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_OPEN:   if (hit) state_d = CFG_LOCKED;   // first write
            CFG_LOCKED: state_d = CFG_LOCKED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_OPEN;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        cfg_load = (state_q == CFG_OPEN) && hit;
        locked   = (state_q == CFG_LOCKED);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cfg_q <= CFG_DEFAULT;
        else if (cfg_load) cfg_q <= wdg_cfg_t'(wr_field);
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/wdg_key_fsm.sv
module wdg_key_fsm
    import wdg_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int SVC_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              svc_fire,
    output logic              bad_key,
    output logic              armed
);

    key_state_e state_q, state_d;
    logic       hit, is_arm, is_fire, is_bad;

    always_comb begin
        hit     = wr_en && (wr_addr == ADDR_W'(SVC_ADDR));
        is_arm  = hit && (wr_data == KEY_ARM_BYTE);
        is_fire = hit && (wr_data == KEY_FIRE_BYTE);
        is_bad  = hit && !is_arm && !is_fire;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_IDLE: begin
                if (is_arm) state_d = KEY_ARMED;            // arm
            end
            KEY_ARMED: begin
                if (is_fire || is_bad) state_d = KEY_IDLE;  // fire / reject
                else if (is_arm)       state_d = KEY_ARMED; // re-arm
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        svc_fire = is_fire && (state_q == KEY_ARMED);
        bad_key  = is_bad;
        armed    = (state_q == KEY_ARMED);
    end

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
#(
    parameter int BUS_EXP1  = 13,
    parameter int BUS_EXP2  = 16,
    parameter int BUS_EXP3  = 18,
    parameter int SLOW_EXP1 = 5,
    parameter int SLOW_EXP2 = 8,
    parameter int SLOW_EXP3 = 10,
    parameter int CNT_W     = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wdg_cfg_t         cfg,
    input  logic             tick_1k,
    input  logic             restart,
    input  logic             svc_fire,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W:0]   limit,
    output logic             early_hit,
    output logic             expire
);

    localparam int LIM_W = CNT_W + 1;

    logic [CNT_W-1:0] count_q, count_d;
    logic [LIM_W-1:0] open_point;
    logic             enabled, inc, last, win_active;
    cnt_phase_e       phase;
    int unsigned      exp_sel;

    always_comb begin
        exp_sel = 0;
        unique case (cfg.sel)
            2'd0: exp_sel = 0;
            2'd1: exp_sel = cfg.bus ? BUS_EXP1 : SLOW_EXP1;
            2'd2: exp_sel = cfg.bus ? BUS_EXP2 : SLOW_EXP2;
            2'd3: exp_sel = cfg.bus ? BUS_EXP3 : SLOW_EXP3;
        endcase
    end

    always_comb begin
        limit      = LIM_W'(1) << exp_sel;
        open_point = limit - (limit >> 2);
        enabled    = (cfg.sel != 2'd0);
        inc        = enabled && (cfg.bus || tick_1k);
        last       = ({1'b0, count_q} == (limit - LIM_W'(1)));
        win_active = enabled && cfg.bus && cfg.win;
    end

    // phase decode
    always_comb begin
        if (!enabled)                          phase = PH_OFF;
        else if ({1'b0, count_q} < open_point) phase = PH_CLOSED;
        else                                   phase = PH_OPEN;
    end

    // next count
    always_comb begin
        count_d = count_q;
        if (restart || !enabled) count_d = '0;
        else if (inc)            count_d = last ? '0 : count_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    // outputs
    always_comb begin
        expire    = inc && last && !restart;
        early_hit = svc_fire && win_active && (phase == PH_CLOSED);
        count     = count_q;
    end

endmodule

// File: rtl/keyseq_watchdog.sv
module keyseq_watchdog
    import wdg_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CFG_ADDR  = 0,
    parameter int SVC_ADDR  = 1,
    parameter int BUS_EXP1  = 13,
    parameter int BUS_EXP2  = 16,
    parameter int BUS_EXP3  = 18,
    parameter int SLOW_EXP1 = 5,
    parameter int SLOW_EXP2 = 8,
    parameter int SLOW_EXP3 = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1k,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              reset_req
);

    localparam int MAX_B = (BUS_EXP1 > BUS_EXP2) ?
                           ((BUS_EXP1 > BUS_EXP3) ? BUS_EXP1 : BUS_EXP3) :
                           ((BUS_EXP2 > BUS_EXP3) ? BUS_EXP2 : BUS_EXP3);
    localparam int MAX_S = (SLOW_EXP1 > SLOW_EXP2) ?
                           ((SLOW_EXP1 > SLOW_EXP3) ? SLOW_EXP1 : SLOW_EXP3) :
                           ((SLOW_EXP2 > SLOW_EXP3) ? SLOW_EXP2 : SLOW_EXP3);
    localparam int CNT_W = (MAX_B > MAX_S) ? MAX_B : MAX_S;

    wdg_cfg_t         cfg;
    logic             cfg_load, cfg_locked;
    logic             svc_fire, bad_key, key_armed;
    logic             early_hit, expire, restart;
    logic [CNT_W-1:0] count;
    logic [CNT_W:0]   limit;
    logic             req_q;

    wdg_cfg_reg #(
        .ADDR_W  (ADDR_W),
        .CFG_ADDR(CFG_ADDR)
    ) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_field(wr_data[3:0]),
        .cfg     (cfg),
        .cfg_load(cfg_load),
        .locked  (cfg_locked)
    );

    wdg_key_fsm #(
        .ADDR_W  (ADDR_W),
        .SVC_ADDR(SVC_ADDR)
    ) key_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .svc_fire(svc_fire),
        .bad_key (bad_key),
        .armed   (key_armed)
    );

    assign restart = cfg_load || svc_fire || bad_key;

    wdg_counter #(
        .BUS_EXP1 (BUS_EXP1),
        .BUS_EXP2 (BUS_EXP2),
        .BUS_EXP3 (BUS_EXP3),
        .SLOW_EXP1(SLOW_EXP1),
        .SLOW_EXP2(SLOW_EXP2),
        .SLOW_EXP3(SLOW_EXP3),
        .CNT_W    (CNT_W)
    ) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg),
        .tick_1k  (tick_1k),
        .restart  (restart),
        .svc_fire (svc_fire),
        .count    (count),
        .limit    (limit),
        .early_hit(early_hit),
        .expire   (expire)
    );

    // registered request pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= bad_key || early_hit || expire;
    end

    assign reset_req = req_q;

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
    parameter int ADDR_W   = 4,
    parameter int SVC_ADDR = 1,
    parameter int CNT_W    = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1k,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              reset_req,
    input logic              cfg_locked,
    input logic [3:0]        cfg_bits,
    input logic              key_armed,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W:0]    limit
);

    logic svc_hit;
    assign svc_hit = wr_en && (wr_addr == ADDR_W'(SVC_ADDR));

    // R5: an illegal service byte is followed by a request
    p_bad_key_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_hit && wr_data != 8'h55 && wr_data != 8'hAA) |=> reset_req);

    // R4: a 0x55 always leaves the sequence pending
    p_arm_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_hit && wr_data == 8'h55) |=> key_armed);

    // R2: count stays inside the selected period
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bits[1:0] != 2'd0) |-> ({1'b0, count} < limit));

    // R6: slow source without a tick holds the count
    p_slow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_bits[2] && !tick_1k && !wr_en) |=> $stable(count));

    // R7: disabled counter never times out
    p_off_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bits[1:0] == 2'd0 && !svc_hit) |=> !reset_req);

    // R10: locked configuration never changes
    p_lock_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> (cfg_locked && $stable(cfg_bits)));

endmodule

bind keyseq_watchdog wdg_checker #(
    .ADDR_W  (ADDR_W),
    .SVC_ADDR(SVC_ADDR),
    .CNT_W   (CNT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1k   (tick_1k),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .reset_req (reset_req),
    .cfg_locked(cfg_locked),
    .cfg_bits  (cfg),
    .key_armed (key_armed),
    .count     (count),
    .limit     (limit)
);

// File: tb/keyseq_watchdog_tb_top.sv
`timescale 1ns/1ps
module keyseq_watchdog_tb_top;

    localparam int AW = 4;
    localparam int CA = 0;
    localparam int SA = 1;
    localparam int B1 = 4, B2 = 5, B3 = 6;
    localparam int S1 = 3, S2 = 4, S3 = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_1k = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          reset_req;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    int tdiv = 0;
    int dut_pulses = 0;
    int mdl_pulses = 0;
    string cur_req = "R1";

    // reference model state
    int  m_sel, m_cnt;
    bit  m_bus, m_win, m_locked, m_armed, m_req;

    always #5 clk = ~clk;

    keyseq_watchdog #(
        .ADDR_W(AW), .CFG_ADDR(CA), .SVC_ADDR(SA),
        .BUS_EXP1(B1), .BUS_EXP2(B2), .BUS_EXP3(B3),
        .SLOW_EXP1(S1), .SLOW_EXP2(S2), .SLOW_EXP3(S3)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .reset_req(reset_req)
    );

    function automatic int lim_of(int sel, bit bus);
        int e;
        case (sel)
            1: e = bus ? B1 : S1;
            2: e = bus ? B2 : S2;
            3: e = bus ? B3 : S3;
            default: e = 0;
        endcase
        return 1 << e;
    endfunction

    // behavioural reference
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sel = 3; m_bus = 0; m_win = 0; m_locked = 0;
            m_armed = 0; m_cnt = 0; m_req = 0;
        end else begin
            bit evt, rst_cnt;
            int lim;
            evt = 0; rst_cnt = 0;
            lim = lim_of(m_sel, m_bus);
            if (wr_en && wr_addr == CA && !m_locked) begin
                m_sel = int'(wr_data[1:0]); m_bus = wr_data[2]; m_win = wr_data[3];
                m_locked = 1; rst_cnt = 1;
            end
            if (wr_en && wr_addr == SA) begin
                if (wr_data == 8'h55) m_armed = 1;
                else if (wr_data == 8'hAA) begin
                    if (m_armed) begin
                        rst_cnt = 1;
                        if (m_sel != 0 && m_bus && m_win && m_cnt * 4 < lim * 3) evt = 1;
                    end
                    m_armed = 0;
                end else begin
                    evt = 1; rst_cnt = 1; m_armed = 0;
                end
            end
            lim = lim_of(m_sel, m_bus);
            if (rst_cnt || m_sel == 0) m_cnt = 0;
            else if (m_bus || tick_1k) begin
                if (m_cnt == lim - 1) begin evt = 1; m_cnt = 0; end
                else m_cnt = m_cnt + 1;
            end
            m_req = evt;
        end
    end

    // tick generator and per-cycle compare
    always @(negedge clk) begin
        cycles++;
        tdiv = (tdiv + 1) % 4;
        tick_1k = (tdiv == 3);
        if (rst_n) begin
            vectors++;
            if (reset_req) dut_pulses++;
            if (m_req) mdl_pulses++;
            if (reset_req !== m_req) begin
                fails++;
                $display("FAIL %s cycle %0d reset_req actual=%0b expected=%0b",
                         cur_req, cycles, reset_req, m_req);
            end
        end
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        idle(2);
        rst_n = 1;
    endtask

    task automatic wr(logic [AW-1:0] a, logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic pulses(int exp_n);
        vectors++;
        if (dut_pulses != exp_n || mdl_pulses != exp_n) begin
            fails++;
            $display("FAIL %s pulse count actual=%0d expected=%0d", cur_req, dut_pulses, exp_n);
        end
        dut_pulses = 0; mdl_pulses = 0;
    endtask

    initial begin
        // R1: reset state and default long slow timeout (32 ticks ~ 128 cycles)
        cur_req = "R1";
        idle(3);
        vectors++;
        if (reset_req !== 1'b0) begin
            fails++; $display("FAIL R1 reset value actual=%0b expected=0", reset_req);
        end
        rst_n = 1;
        dut_pulses = 0; mdl_pulses = 0;
        idle(140);
        pulses(1);

        // R2, R6, R7: bus clock, field 1 -> 16 cycles
        cur_req = "R2"; do_reset(); wr(CA, 8'h05); idle(50); pulses(3);
        cur_req = "R7"; do_reset(); wr(CA, 8'h06); idle(70); pulses(2);
        cur_req = "R7"; do_reset(); wr(CA, 8'h07); idle(70); pulses(1);
        cur_req = "R7"; do_reset(); wr(CA, 8'h04); idle(200); pulses(0);
        // R6: slow field 1 -> 8 ticks ~ 32 cycles
        cur_req = "R6"; do_reset(); wr(CA, 8'h01); idle(70); pulses(2);

        // R3: keep servicing a 64-cycle bus timeout
        cur_req = "R3"; do_reset(); wr(CA, 8'h07);
        for (int i = 0; i < 4; i++) begin
            idle(40); wr(SA, 8'h55); idle(5); wr(SA, 8'hAA);
        end
        pulses(0);

        // R4: lone 0xAA does not service; double 0x55 still pending
        cur_req = "R4"; do_reset(); wr(CA, 8'h07);
        idle(30); wr(SA, 8'hAA); idle(40); pulses(1);
        do_reset(); wr(CA, 8'h07);
        idle(30); wr(SA, 8'h55); wr(SA, 8'h55); wr(SA, 8'hAA); idle(40); pulses(0);

        // R5: illegal key byte
        cur_req = "R5"; do_reset(); wr(CA, 8'h07); idle(5); wr(SA, 8'h12); idle(3); pulses(1);
        wr(SA, 8'h55); wr(SA, 8'h00); idle(3); pulses(1);

        // R8: window on bus, field 2 (32 cycles, open from 24)
        cur_req = "R8"; do_reset(); wr(CA, 8'h0E); idle(8); wr(SA, 8'h55); wr(SA, 8'hAA);
        idle(3); pulses(1);
        do_reset(); wr(CA, 8'h0E); idle(24); wr(SA, 8'h55); wr(SA, 8'hAA); idle(20); pulses(0);

        // R9: window bit ignored with slow source
        cur_req = "R9"; do_reset(); wr(CA, 8'h09); idle(2); wr(SA, 8'h55); wr(SA, 8'hAA);
        idle(10); pulses(0);

        // R10: first write clears count; second write ignored
        cur_req = "R10"; do_reset(); idle(100); wr(CA, 8'h05); wr(CA, 8'h07); idle(40); pulses(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule